// File: doc/BRIEF.md
# PWM ADC Start-Trigger Source Selector

This block sits beside one channel pair of a PWM unit. It turns one chosen PWM timing event into a one-clock start pulse for an analog-to-digital converter. The event strobes of the pair's even and odd channels come in as inputs: zero point, period point, compare match while counting up, and compare match while counting down. The counter value and count direction of every channel pair in the build also come in, and they drive free-trigger comparators. Each free-trigger comparator has its own 16-bit threshold register, separate from any duty comparator. The register is a shadow copy that takes a new value only at that pair's period boundary.

A 4-bit source code picks the event. Codes 0 to 9 cover five events on each channel of the pair, one of them the union of zero point and period point. Codes 10 to 15 pick a free-comparator match, split by count direction, on up to three pairs. Each pulse also sets a sticky flag, which the host clears. An enable input suppresses both the pulse and the flag.

Top module: `pwm_adc_trig_sel`

## Requirements
- R1: During and right after reset, `adc_trig` and `trig_flag` are 0.
- R2: Each event strobe vector uses bit 0 for zero point, bit 1 for period point, bit 2 for compare while counting up and bit 3 for compare while counting down. Codes 0, 1, 3 and 4 select bits 0, 1, 2 and 3 of `ev_even`. Code 2 selects bit 0 OR bit 1 of `ev_even`.
- R3: Codes 5 to 9 select the same five events, in the same order, from `ev_odd`.
- R4: For pair k, code 10+2k selects a free-comparator match while `cnt_up[k]`=1 (counting up), and code 11+2k selects a match while `cnt_up[k]`=0. A match is the first cycle in which the pair's counter equals its active threshold. A cycle in which equality continues from the cycle before is not a match, and neither is the first cycle after reset.
- R5: The active threshold of pair k is 0 after reset. It takes the value of `ftc_val` slice k only in a cycle where `prd_load[k]`=1, and that new value is used for equality from the next cycle on.
- R6: `adc_trig` is 1 in the cycle after a cycle in which the selected event is present and the enable is 1. It is 0 in every other cycle, so one event cycle gives exactly one pulse cycle.
- R7: `trig_flag` becomes 1 together with every `adc_trig` pulse and holds until a cycle with `flag_clr`=1 and no pulse. If a pulse and a clear fall in the same cycle, the flag stays 1.
- R8: While `trig_en`=0, events produce neither a pulse nor a flag set.
- R9: Codes that name a pair not present in the build (k ≥ PAIR_CNT) never produce a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_en | input | 1 | Trigger enable |
| src_sel | input | 4 | Event source code |
| ev_even | input | 4 | Even channel event strobes |
| ev_odd | input | 4 | Odd channel event strobes |
| cnt_val | input | PAIR_CNT*CW | Counter value of each pair, pair k at bits k*CW |
| cnt_up | input | PAIR_CNT | Count direction per pair, 1 = up |
| ftc_val | input | PAIR_CNT*CW | Free-trigger threshold register value per pair |
| prd_load | input | PAIR_CNT | Period-boundary load strobe per pair |
| flag_clr | input | 1 | Host clear of the trigger flag |
| adc_trig | output | 1 | One-clock ADC start pulse |
| trig_flag | output | 1 | Sticky trigger flag |

## Verification
Random strobes on both channels at once show whether a code reads the wrong channel or the wrong bit. The zero-or-period code is told apart from its two neighbours by cycles in which only one of those two bits is set. Counters and thresholds are drawn from a set of four values, with random direction and random loads. This makes equality start, continue and end often, and so separates an edge-qualified match from a level match, an up match from a down match, and a threshold loaded at once from one loaded at the period boundary. Directed steps cover a delayed threshold load, a single isolated pulse, a clear in the same cycle as a pulse, and codes for pairs that are not built.

// File: rtl/pwm_atrg_pkg.sv
package pwm_atrg_pkg;

   localparam int MAX_PAIRS = 3;

   // bit positions inside an event strobe vector
   localparam int EV_ZERO = 0;
   localparam int EV_PRD  = 1;
   localparam int EV_CUP  = 2;
   localparam int EV_CDN  = 3;

   typedef enum logic [3:0] {
      SRC_E_ZERO = 4'd0,
      SRC_E_PRD  = 4'd1,
      SRC_E_ZOP  = 4'd2,
      SRC_E_CUP  = 4'd3,
      SRC_E_CDN  = 4'd4,
      SRC_O_ZERO = 4'd5,
      SRC_O_PRD  = 4'd6,
      SRC_O_ZOP  = 4'd7,
      SRC_O_CUP  = 4'd8,
      SRC_O_CDN  = 4'd9,
      SRC_F0_UP  = 4'd10,
      SRC_F0_DN  = 4'd11,
      SRC_F1_UP  = 4'd12,
      SRC_F1_DN  = 4'd13,
      SRC_F2_UP  = 4'd14,
      SRC_F2_DN  = 4'd15
   } atrg_src_e;

   // five-way event view of one channel's strobes
   function automatic logic [4:0] chan_events(input logic [3:0] ev);
      return {ev[EV_CDN], ev[EV_CUP], ev[EV_ZERO] | ev[EV_PRD], ev[EV_PRD], ev[EV_ZERO]};
   endfunction

endpackage

// File: rtl/pwm_atrg_fmatch.sv
module pwm_atrg_fmatch #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cnt,
   input  logic          cnt_up,
   input  logic [CW-1:0] ftc_val,
   input  logic          prd_load,
   output logic          hit_up,
   output logic          hit_dn
);

   generate
      if (CW < 2 || CW > 32) begin : g_bad_cw
         $error("pwm_atrg_fmatch: CW out of range");
      end
   endgenerate

   logic [CW-1:0] thr_act;
   logic          eq_now;
   logic          eq_prev;
   logic          hit;

   // active threshold copy, moved only at the period boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        thr_act <= '0;
      else if (prd_load) thr_act <= ftc_val;
   end

   assign eq_now = (cnt == thr_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) eq_prev <= 1'b1;
      else        eq_prev <= eq_now;
   end

   assign hit    = eq_now & ~eq_prev;
   assign hit_up = hit & cnt_up;
   assign hit_dn = hit & ~cnt_up;

   // R5
   thr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prd_load |=> thr_act == $past(ftc_val));

   // R5
   thr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !prd_load |=> $stable(thr_act));

   // R4
   match_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_up || hit_dn) |=> !(hit_up || hit_dn));

endmodule

// File: rtl/pwm_atrg_src_mux.sv
module pwm_atrg_src_mux
   import pwm_atrg_pkg::*;
#(
   parameter int PAIR_CNT = 3
) (
   input  logic [3:0]          sel,
   input  logic [3:0]          ev_even,
   input  logic [3:0]          ev_odd,
   input  logic [PAIR_CNT-1:0] fm_up,
   input  logic [PAIR_CNT-1:0] fm_dn,
   output logic                hit
);

   localparam int NCODES = 16;
   localparam int FM_BASE = int'(SRC_F0_UP);
   localparam int FIRST_FREE = FM_BASE + 2 * PAIR_CNT;

   logic [NCODES-1:0] cand;

   assign cand[4:0] = chan_events(ev_even);
   assign cand[9:5] = chan_events(ev_odd);

   generate
      for (genvar p = 0; p < MAX_PAIRS; p++) begin : g_fm
         if (p < PAIR_CNT) begin : g_on
            assign cand[FM_BASE + 2*p]     = fm_up[p];
            assign cand[FM_BASE + 2*p + 1] = fm_dn[p];
         end else begin : g_off
            assign cand[FM_BASE + 2*p]     = 1'b0;
            assign cand[FM_BASE + 2*p + 1] = 1'b0;
         end
      end
   endgenerate

   assign hit = cand[sel];

   // R9
   always_comb begin
      if (int'(sel) >= FIRST_FREE) begin
         absent_pair_chk: assert (!hit);
      end
   end

endmodule

// File: rtl/pwm_adc_trig_sel.sv
module pwm_adc_trig_sel
   import pwm_atrg_pkg::*;
#(
   parameter int CW       = 16,
   parameter int PAIR_CNT = 3
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   trig_en,
   input  logic [3:0]             src_sel,
   input  logic [3:0]             ev_even,
   input  logic [3:0]             ev_odd,
   input  logic [PAIR_CNT*CW-1:0] cnt_val,
   input  logic [PAIR_CNT-1:0]    cnt_up,
   input  logic [PAIR_CNT*CW-1:0] ftc_val,
   input  logic [PAIR_CNT-1:0]    prd_load,
   input  logic                   flag_clr,
   output logic                   adc_trig,
   output logic                   trig_flag
);

   generate
      if (PAIR_CNT < 1 || PAIR_CNT > MAX_PAIRS) begin : g_bad_pairs
         $error("pwm_adc_trig_sel: PAIR_CNT must be 1..3");
      end
   endgenerate

   logic [PAIR_CNT-1:0] fm_up;
   logic [PAIR_CNT-1:0] fm_dn;
   logic                sel_hit;
   logic                trig_nxt;

   generate
      for (genvar p = 0; p < PAIR_CNT; p++) begin : g_pair
         pwm_atrg_fmatch #(.CW(CW)) u_fm (
            .clk      (clk),
            .rst_n    (rst_n),
            .cnt      (cnt_val[p*CW +: CW]),
            .cnt_up   (cnt_up[p]),
            .ftc_val  (ftc_val[p*CW +: CW]),
            .prd_load (prd_load[p]),
            .hit_up   (fm_up[p]),
            .hit_dn   (fm_dn[p])
         );
      end
   endgenerate

   pwm_atrg_src_mux #(.PAIR_CNT(PAIR_CNT)) u_mux (
      .sel     (src_sel),
      .ev_even (ev_even),
      .ev_odd  (ev_odd),
      .fm_up   (fm_up),
      .fm_dn   (fm_dn),
      .hit     (sel_hit)
   );

   assign trig_nxt = trig_en & sel_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) adc_trig <= 1'b0;
      else        adc_trig <= trig_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        trig_flag <= 1'b0;
      else if (trig_nxt) trig_flag <= 1'b1;
      else if (flag_clr) trig_flag <= 1'b0;
   end

   // R8
   gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_en |=> !adc_trig);

   // R7
   flag_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      adc_trig |-> trig_flag);

   // R7
   flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_flag && !flag_clr) |=> trig_flag);

   // R7
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(trig_flag) |-> adc_trig);

   // R6
   pulse_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_en && sel_hit) |=> adc_trig);

endmodule

// File: tb/tb_pwm_adc_trig_sel.sv
module tb_pwm_adc_trig_sel;
   localparam int CW = 16;
   localparam int NP = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic             rst_n;
   logic             trig_en;
   logic [3:0]       src_sel;
   logic [3:0]       ev_even, ev_odd;
   logic [NP*CW-1:0] cnt_val, ftc_val;
   logic [NP-1:0]    cnt_up, prd_load;
   logic             flag_clr;
   logic             adc_trig, trig_flag;

   pwm_adc_trig_sel #(.CW(CW), .PAIR_CNT(NP)) dut (
      .clk(clk), .rst_n(rst_n), .trig_en(trig_en), .src_sel(src_sel),
      .ev_even(ev_even), .ev_odd(ev_odd), .cnt_val(cnt_val), .cnt_up(cnt_up),
      .ftc_val(ftc_val), .prd_load(prd_load), .flag_clr(flag_clr),
      .adc_trig(adc_trig), .trig_flag(trig_flag)
   );

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   string force_tag = "";

   logic [CW-1:0] m_thr [NP];
   logic          m_eqp [NP];
   logic          m_trig, m_flag;

   function automatic logic ev_of(logic [3:0] code, logic [3:0] ee, logic [3:0] eo,
                                  logic [NP-1:0] fh, logic [NP-1:0] up);
      int k;
      case (code)
         4'd0: return ee[0];
         4'd1: return ee[1];
         4'd2: return ee[0] | ee[1];
         4'd3: return ee[2];
         4'd4: return ee[3];
         4'd5: return eo[0];
         4'd6: return eo[1];
         4'd7: return eo[0] | eo[1];
         4'd8: return eo[2];
         4'd9: return eo[3];
         default: begin
            k = (int'(code) - 10) / 2;
            if (k >= NP) return 1'b0;
            if (code[0] == 1'b0) return fh[k] & up[k];
            return fh[k] & ~up[k];
         end
      endcase
   endfunction

   function automatic string tag_of(logic en, logic [3:0] code);
      if (!en) return "R8";
      if (code < 4'd5) return "R2";
      if (code < 4'd10) return "R3";
      if ((int'(code) - 10) / 2 < NP) return "R4";
      return "R9";
   endfunction

   task automatic chk(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
      end
   endtask

   // drive one cycle at a falling edge, advance the model, check at the next falling edge
   task automatic step(logic en, logic [3:0] sel, logic [3:0] ee, logic [3:0] eo,
                       logic clr, logic [NP-1:0] ld, logic [NP*CW-1:0] cv,
                       logic [NP-1:0] up, logic [NP*CW-1:0] fv);
      logic [NP-1:0] fh;
      logic          eq;
      string         t;
      trig_en = en; src_sel = sel; ev_even = ee; ev_odd = eo; flag_clr = clr;
      prd_load = ld; cnt_val = cv; cnt_up = up; ftc_val = fv;
      for (int k = 0; k < NP; k++) begin
         eq = (cv[k*CW +: CW] == m_thr[k]);
         fh[k] = eq & ~m_eqp[k];
         m_eqp[k] = eq;
         if (ld[k]) m_thr[k] = fv[k*CW +: CW];
      end
      m_trig = en & ev_of(sel, ee, eo, fh, up);
      m_flag = m_trig | (m_flag & ~clr);
      @(negedge clk);
      t = (force_tag != "") ? force_tag : tag_of(en, sel);
      chk(t, "adc_trig", adc_trig, m_trig);
      chk((force_tag != "") ? force_tag : "R7", "trig_flag", trig_flag, m_flag);
   endtask

   function automatic logic [NP*CW-1:0] small_vec();
      logic [NP*CW-1:0] v = '0;
      for (int k = 0; k < NP; k++) v[k*CW +: CW] = CW'($urandom_range(0, 3));
      return v;
   endfunction

   initial begin
      #(8 * 100000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [NP*CW-1:0] c;
      logic [NP*CW-1:0] f;
      void'($urandom(32'd4242));
      rst_n = 1'b0; trig_en = 0; src_sel = 0; ev_even = 0; ev_odd = 0;
      cnt_val = '0; ftc_val = '0; cnt_up = '0; prd_load = '0; flag_clr = 0;
      for (int k = 0; k < NP; k++) begin m_thr[k] = '0; m_eqp[k] = 1'b1; end
      m_trig = 0; m_flag = 0;
      repeat (3) @(negedge clk);
      chk("R1", "adc_trig in reset", adc_trig, 1'b0);
      chk("R1", "trig_flag in reset", trig_flag, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "adc_trig after reset", adc_trig, 1'b0);
      chk("R1", "trig_flag after reset", trig_flag, 1'b0);

      // R6: one isolated event cycle gives one pulse cycle
      force_tag = "R6";
      step(1, 4'd1, 4'b0010, 4'b0000, 0, '0, {16'd9, 16'd9}, '0, '0);
      step(1, 4'd1, 4'b0000, 4'b0000, 0, '0, {16'd9, 16'd9}, '0, '0);
      // R7: clear together with a pulse keeps the flag, then clear alone drops it
      force_tag = "R7";
      step(1, 4'd6, 4'b0000, 4'b0010, 1, '0, {16'd9, 16'd9}, '0, '0);
      step(1, 4'd6, 4'b0000, 4'b0000, 1, '0, {16'd9, 16'd9}, '0, '0);
      // R5: threshold written but loaded only at the boundary
      force_tag = "R5";
      step(1, 4'd10, 4'b0, 4'b0, 0, '0, {16'd9, 16'd7}, 2'b11, {16'd0, 16'd5});
      step(1, 4'd10, 4'b0, 4'b0, 0, '0, {16'd9, 16'd5}, 2'b11, {16'd0, 16'd5});
      step(1, 4'd10, 4'b0, 4'b0, 0, 2'b01, {16'd9, 16'd6}, 2'b11, {16'd0, 16'd5});
      step(1, 4'd10, 4'b0, 4'b0, 0, '0, {16'd9, 16'd5}, 2'b11, {16'd0, 16'd5});
      step(1, 4'd10, 4'b0, 4'b0, 0, '0, {16'd9, 16'd5}, 2'b11, {16'd0, 16'd5});
      // R9: codes of an absent pair
      force_tag = "R9";
      step(1, 4'd14, 4'hF, 4'hF, 0, '0, {16'd1, 16'd1}, 2'b11, '0);
      step(1, 4'd15, 4'hF, 4'hF, 0, '0, {16'd0, 16'd0}, 2'b00, '0);
      // R8: disabled with events present
      force_tag = "R8";
      step(1, 4'd0, 4'b0, 4'b0, 1, '0, {16'd9, 16'd9}, '0, '0);
      step(0, 4'd0, 4'hF, 4'hF, 0, '0, {16'd9, 16'd9}, '0, '0);
      force_tag = "";

      for (int i = 0; i < 4000; i++) begin
         c = small_vec();
         f = small_vec();
         step(($urandom_range(0, 3) != 0), 4'($urandom_range(0, 15)),
              4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)),
              4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)),
              ($urandom_range(0, 3) == 0), NP'($urandom_range(0, 3)) & NP'($urandom_range(0, 3)),
              c, NP'($urandom_range(0, 3)), f);
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule